// File: doc/BRIEF.md
# DS3 Alarm Indication Signal Generator

This block produces a DS3 alarm indication signal as a serial stream. Each clock cycle in which the bit strobe is high moves the stream on by one bit. The block keeps its own count of the position in the 4760-bit M-frame. There are two patterns. The framed pattern carries the usual overhead: correct F and M alignment bits, X bits held at one, C bits held at zero, and two P bits that carry the parity of the previous frame's payload. Between overhead bits the payload alternates 1,0,1,0, and it restarts with a one after every overhead bit. The unframed pattern is a stream of ones, which can stand in for any framing mode.

The enable and the pattern select are sampled only on the first bit of an M-frame. A change made partway through a frame therefore waits for the next frame boundary, so every emitted frame is whole. This lets the alarm start and stop without framing, P-bit or CP-bit errors. The frame count runs whether the alarm is on or off, so a start-of-frame pulse always marks the frame grid.

Top module: `ds3_ais_gen`

## Requirements
- R1: After reset, `ser_out` and `sof` are both 0, and the first strobed bit is position 0 of a new M-frame.
- R2: Positions are counted only on strobed cycles. A frame is 7 subframes of 8 blocks, and each block is 85 bits: position 0 is overhead, positions 1..84 are payload (4760 bits per frame). `sof` is high for exactly one cycle, the cycle after the strobe that emits frame position 0.
- R3: In framed mode, the overhead bits of blocks 1, 3, 5 and 7 of every subframe (blocks numbered 0..7) are the F bits 1, 0, 0, 1. The overhead bits of blocks 2, 4 and 6 are C bits and are 0.
- R4: In framed mode, the block-0 overhead bit is X = 1 in subframes 0 and 1 and is a P bit in subframes 2 and 3. In subframes 4, 5 and 6 it is the M bit 0, 1, 0 (subframes numbered 0..6).
- R5: In framed mode, payload position k (1..84) of every block is 1 when k is odd and 0 when k is even.
- R6: Both P bits equal the modulo-2 sum of all payload bits the block emitted in the previous frame, whatever pattern that frame used. In the first frame after reset they are 0.
- R7: In unframed mode, every bit is 1.
- R8: When the enable is low, every bit is 0, and the frame count and `sof` keep running.
- R9: `ais_en` and `framed` are sampled only with the strobe of frame position 0. Changes at other times have no effect until the next frame.
- R10: In a cycle without the strobe, `ser_out` holds its value and the position does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit strobe: emit the next bit |
| ais_en | input | 1 | Alarm enable (1 = emit the pattern, 0 = emit zeros) |
| framed | input | 1 | Pattern select: 1 = framed AIS, 0 = all ones |
| ser_out | output | 1 | Serial data bit, held between strobes |
| sof | output | 1 | One-cycle pulse for the first bit of an M-frame |

## Verification
The bound checker checks four things on every cycle:
- `sof` never lasts two cycles, and a frame start always carries the sampled enable on the X bit.
- A disabled frame emits only zeros and an unframed frame only ones.
- The data bit holds when there is no strobe.
- The latched mode changes only on a frame-start strobe.

The actual contents of the framed overhead, the payload phase after each overhead bit, the parity carried from one frame into the next, and the deferral of mid-frame mode changes can only be shown by the bench. It sweeps every bit position of consecutive frames in all three modes and compares each bit with a value computed from its position.

// File: rtl/ds3_ais_gen.sv
module ds3_ais_gen #(
  parameter int PAY_BITS = 84
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic ais_en,
  input  logic framed,
  output logic ser_out,
  output logic sof
);
  localparam int BLOCKS    = 8;
  localparam int SUBFRAMES = 7;
  localparam int PW        = $clog2(PAY_BITS + 1);
  localparam int BW        = $clog2(BLOCKS);
  localparam int SW        = $clog2(SUBFRAMES);

  logic [PW-1:0] pos;
  logic [BW-1:0] blk;
  logic [SW-1:0] sf;
  logic on_q, fr_q, par_acc, p_q;
  logic oh_bit;

  wire blk_end  = (pos == PW'(PAY_BITS));
  wire at_start = (pos == '0) && (blk == '0) && (sf == '0);
  wire at_last  = blk_end && (blk == BW'(BLOCKS - 1)) && (sf == SW'(SUBFRAMES - 1));
  wire cur_on   = at_start ? ais_en : on_q;
  wire cur_fr   = at_start ? framed : fr_q;

  always_comb begin
    case (blk)
      3'd0:    oh_bit = (sf < 3'd2) ? 1'b1 : (sf < 3'd4) ? p_q : (sf == 3'd5);
      3'd1:    oh_bit = 1'b1;
      3'd7:    oh_bit = 1'b1;
      default: oh_bit = 1'b0;
    endcase
  end

  wire frm_bit = (pos == '0) ? oh_bit : pos[0];
  wire nxt_bit = cur_on & (~cur_fr | frm_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos     <= '0;
      blk     <= '0;
      sf      <= '0;
      on_q    <= 1'b0;
      fr_q    <= 1'b0;
      par_acc <= 1'b0;
      p_q     <= 1'b0;
      ser_out <= 1'b0;
      sof     <= 1'b0;
    end else begin
      sof <= 1'b0;
      if (bit_en) begin
        ser_out <= nxt_bit;
        sof     <= at_start;
        on_q    <= cur_on;
        fr_q    <= cur_fr;
        if (at_last) begin
          p_q     <= par_acc ^ nxt_bit;
          par_acc <= 1'b0;
        end else if (pos != '0) begin
          par_acc <= par_acc ^ nxt_bit;
        end
        if (blk_end) begin
          pos <= '0;
          if (blk == BW'(BLOCKS - 1)) begin
            blk <= '0;
            sf  <= (sf == SW'(SUBFRAMES - 1)) ? '0 : sf + 1'b1;
          end else begin
            blk <= blk + 1'b1;
          end
        end else begin
          pos <= pos + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ds3_ais_gen_chk.sv
module ds3_ais_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic ser_out,
  input logic sof,
  input logic on_q,
  input logic fr_q,
  input logic at_start
);
  // R2
  sof_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) sof |=> !sof);
  // R4
  sof_xbit_chk: assert property (@(posedge clk) disable iff (!rst_n) sof |-> (ser_out == on_q));
  // R8
  off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) !on_q |-> !ser_out);
  // R7
  unfr_ones_chk: assert property (@(posedge clk) disable iff (!rst_n) (on_q && !fr_q) |-> ser_out);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !bit_en |=> $stable(ser_out));
  // R9
  mode_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_en && at_start) |=> ($stable(on_q) && $stable(fr_q)));
endmodule

bind ds3_ais_gen ds3_ais_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_out(ser_out), .sof(sof),
  .on_q(on_q), .fr_q(fr_q), .at_start(at_start)
);

// File: tb/ds3_ais_gen_bench.sv
`timescale 1ns/1ps
module ds3_ais_gen_bench;
  localparam int FRAME = 4760;
  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, ais_en = 1'b0, framed = 1'b0;
  logic ser_out, sof;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  ds3_ais_gen u_ds3_ais_gen (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ais_en(ais_en),
    .framed(framed), .ser_out(ser_out), .sof(sof)
  );

  function automatic logic exp_bit(int p, logic on, logic fr, logic pp);
    int r, sf, b, o;
    r = p % FRAME; sf = r / 680; b = (r % 680) / 85; o = r % 85;
    if (!on) return 1'b0;
    if (!fr) return 1'b1;
    if (o != 0) return logic'(o % 2);
    case (b)
      0: return (sf < 2) ? 1'b1 : (sf < 4) ? pp : logic'(sf == 5);
      1, 7: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag(int p, logic on, logic fr);
    int r, sf, b, o;
    r = p % FRAME; sf = r / 680; b = (r % 680) / 85; o = r % 85;
    if (!on) return "R8";
    if (!fr) return "R7";
    if (o != 0) return "R5";
    if (b != 0) return "R3";
    if (sf == 2 || sf == 3) return "R6";
    return "R4";
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // frame schedule: {ais_en, framed}
  logic [1:0] sched [7] = '{2'b11, 2'b11, 2'b10, 2'b11, 2'b00, 2'b11, 2'b10};

  initial begin
    int pos = 0, cyc = 0, fidx = 0;
    logic m_on = 1'b0, m_fr = 1'b0, pprev = 1'b0, acc = 1'b0, last = 1'b0, e;
    repeat (3) @(posedge clk);
    #1;
    check("R1", ser_out, 1'b0);
    check("R1", sof, 1'b0);
    {ais_en, framed} = sched[0];
    @(negedge clk);
    rst_n = 1'b1;
    while (pos < FRAME * 7) begin
      @(negedge clk);
      bit_en = (cyc % 7) != 6;
      cyc++;
      // R9: next frame's mode is applied in the middle of the current one
      if (pos % FRAME == 2000 && fidx + 1 < 7) {ais_en, framed} = sched[fidx + 1];
      if (pos % FRAME == 3000) {ais_en, framed} = ~{ais_en, framed};
      if (pos % FRAME == 4000 && fidx + 1 < 7) {ais_en, framed} = sched[fidx + 1];
      if (bit_en && pos % FRAME == 0) begin
        {m_on, m_fr} = {ais_en, framed};
        fidx = pos / FRAME;
      end
      @(posedge clk);
      #1;
      if (bit_en) begin
        e = exp_bit(pos, m_on, m_fr, pprev);
        check(tag(pos, m_on, m_fr), ser_out, e);
        check("R2", sof, logic'(pos % FRAME == 0));
        if (pos % 85 != 0) acc ^= e;
        if (pos % FRAME == FRAME - 1) begin pprev = acc; acc = 1'b0; end
        last = e;
        pos++;
      end else begin
        check("R10", ser_out, last);
        check("R2", sof, 1'b0);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule